// File: doc/BRIEF.md
# Asymmetric Converter Clock Prescaler

This block divides a fast system clock into a slow clock for a data converter. Software sets the high phase and the low phase of the slow clock on their own. The high-phase field is 5 bits wide and the low-phase field is 3 bits wide, so both the period and the duty cycle are programmable. The output level is a register in the system-clock domain. Single-cycle strobes mark each rising and falling transition, so downstream logic can act on the slow clock without a second clock domain.

A single-bit legacy field sits beside the two phase fields. It is stored and read back but does not change the output. A conversion timer is also built in. A start pulse arms it, it counts a fixed number of slow-clock rising edges, and it then signals completion with a one-cycle done strobe.

Top module: `conv_clk_div`

## Requirements
- R1: Synchronous reset (`rst` high) clears all three stored fields to zero and drives `qclk`, both strobes, `conv_busy` and `conv_done` low. In the first cycle after reset is released, `qclk` is low. In the following cycle it is high.
- R2: Each high phase of `qclk` lasts exactly `cfg_hi_q + 1` system cycles, for every value of the 5-bit field.
- R3: Each low phase of `qclk` lasts exactly `cfg_lo_q + 1` system cycles, for every value of the 3-bit field. The period is the sum of the two phases: values 11 and 7 give a 20-cycle period, and values 7 and 7 give a 16-cycle period.
- R4: `rise_stb` is high only in the first cycle of each high phase, and `fall_stb` is high only in the first cycle of each low phase. Each strobe therefore appears once per period.
- R5: A cycle with `cfg_we` high loads `cfg_hi`, `cfg_lo` and `cfg_legacy`. The new values appear on `cfg_hi_q`, `cfg_lo_q` and `cfg_legacy_q` in the next cycle.
- R6: A newly stored phase value applies only to phases that begin after it is stored. The phase in progress keeps its original length.
- R7: `cfg_legacy` is stored and read back on `cfg_legacy_q`, but it has no effect on `qclk` or on the strobes.
- R8: When `conv_start` is high while the timer is idle, `conv_busy` is high from the next cycle. The timer counts the `rise_stb` cycles that follow the start cycle. The cycle after the 14th such cycle, `conv_done` is high for one cycle and `conv_busy` is low.
- R9: `conv_start` has no effect while `conv_busy` is high.
- R10: With both phase fields at zero, `qclk` toggles every system cycle, which gives the shortest period of 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write enable for the prescaler fields |
| cfg_hi | input | 5 | High-phase length minus one |
| cfg_lo | input | 3 | Low-phase length minus one |
| cfg_legacy | input | 1 | Legacy field, stored only |
| cfg_hi_q | output | 5 | Stored high-phase field |
| cfg_lo_q | output | 3 | Stored low-phase field |
| cfg_legacy_q | output | 1 | Stored legacy field |
| qclk | output | 1 | Divided clock level |
| rise_stb | output | 1 | First cycle of a high phase |
| fall_stb | output | 1 | First cycle of a low phase |
| conv_start | input | 1 | Arms the conversion timer |
| conv_busy | output | 1 | Conversion timer running |
| conv_done | output | 1 | One-cycle end-of-conversion strobe |

## Verification
The assertions assume that reset is held for at least two cycles before any check applies. This ensures that the history of `qclk` seen by the edge properties is already the reset value. They also assume that the write port and `conv_start` change only between clock edges. The stimulus holds reset for four cycles and drives every input on the falling edge. It pulses `conv_start` for a single cycle, including one pulse that lands deliberately in the middle of a running conversion. The sweep writes all 256 pairs of phase values and lets two phase boundaries pass before it measures. This keeps any measured phase from straddling a write.

// File: rtl/conv_clk_div.sv
module conv_clk_div #(
  parameter int HI_W = 5,
  parameter int LO_W = 3,
  parameter int CONV_PERIODS = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [HI_W-1:0] cfg_hi,
  input  logic [LO_W-1:0] cfg_lo,
  input  logic            cfg_legacy,
  output logic [HI_W-1:0] cfg_hi_q,
  output logic [LO_W-1:0] cfg_lo_q,
  output logic            cfg_legacy_q,
  output logic            qclk,
  output logic            rise_stb,
  output logic            fall_stb,
  input  logic            conv_start,
  output logic            conv_busy,
  output logic            conv_done
);
  localparam int CW = (HI_W > LO_W) ? HI_W : LO_W;
  localparam int TW = $clog2(CONV_PERIODS + 1);
  localparam logic [TW-1:0] LAST = TW'(CONV_PERIODS - 1);

  logic [CW-1:0] cnt, lim;
  logic [TW-1:0] seen;

  wire at_end = (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_hi_q     <= '0;
      cfg_lo_q     <= '0;
      cfg_legacy_q <= 1'b0;
    end else if (cfg_we) begin
      cfg_hi_q     <= cfg_hi;
      cfg_lo_q     <= cfg_lo;
      cfg_legacy_q <= cfg_legacy;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qclk     <= 1'b0;
      cnt      <= '0;
      lim      <= '0;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end else begin
      rise_stb <= at_end & ~qclk;
      fall_stb <= at_end & qclk;
      if (at_end) begin
        qclk <= ~qclk;
        cnt  <= '0;
        lim  <= qclk ? CW'(cfg_lo_q) : CW'(cfg_hi_q);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_busy <= 1'b0;
      conv_done <= 1'b0;
      seen      <= '0;
    end else begin
      conv_done <= 1'b0;
      if (!conv_busy) begin
        if (conv_start) begin
          conv_busy <= 1'b1;
          seen      <= '0;
        end
      end else if (rise_stb) begin
        if (seen == LAST) begin
          conv_busy <= 1'b0;
          conv_done <= 1'b1;
          seen      <= '0;
        end else begin
          seen <= seen + 1'b1;
        end
      end
    end
  end
endmodule

module conv_clk_div_chk #(
  parameter int HI_W = 5,
  parameter int LO_W = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_we,
  input logic [HI_W-1:0] cfg_hi,
  input logic [LO_W-1:0] cfg_lo,
  input logic            cfg_legacy,
  input logic [HI_W-1:0] cfg_hi_q,
  input logic [LO_W-1:0] cfg_lo_q,
  input logic            cfg_legacy_q,
  input logic            qclk,
  input logic            rise_stb,
  input logic            fall_stb,
  input logic            conv_start,
  input logic            conv_busy,
  input logic            conv_done
);
  logic [HI_W:0] run;
  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else     run <= qclk ? run + 1'b1 : '0;
  end

  AST_HIGH_BOUNDED: assert property (@(posedge clk) disable iff (rst) qclk |-> run < (HI_W+1)'(2**HI_W)); // R2
  AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (rst) $rose(qclk) |-> rise_stb); // R4
  AST_FALL_ON_EDGE: assert property (@(posedge clk) disable iff (rst) $fell(qclk) |-> fall_stb); // R4
  AST_RISE_IN_HIGH: assert property (@(posedge clk) disable iff (rst) rise_stb |-> qclk); // R4
  AST_FALL_IN_LOW: assert property (@(posedge clk) disable iff (rst) fall_stb |-> !qclk); // R4
  AST_FIELDS_LOADED: assert property (@(posedge clk) disable iff (rst) cfg_we |=> (cfg_hi_q == $past(cfg_hi)) && (cfg_lo_q == $past(cfg_lo))); // R5
  AST_LEGACY_LOADED: assert property (@(posedge clk) disable iff (rst) cfg_we |=> cfg_legacy_q == $past(cfg_legacy)); // R7
  AST_START_ARMS: assert property (@(posedge clk) disable iff (rst) (conv_start && !conv_busy) |=> conv_busy); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst) conv_done |-> !conv_busy && $past(conv_busy) && $past(rise_stb)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) conv_done |=> !conv_done); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst) (conv_busy && !rise_stb) |=> conv_busy); // R9
endmodule

bind conv_clk_div conv_clk_div_chk #(.HI_W(HI_W), .LO_W(LO_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo),
  .cfg_legacy(cfg_legacy), .cfg_hi_q(cfg_hi_q), .cfg_lo_q(cfg_lo_q),
  .cfg_legacy_q(cfg_legacy_q), .qclk(qclk), .rise_stb(rise_stb),
  .fall_stb(fall_stb), .conv_start(conv_start), .conv_busy(conv_busy),
  .conv_done(conv_done)
);

// File: tb/conv_clk_div_test.sv
module conv_clk_div_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_hi = '0;
  logic [2:0] cfg_lo = '0;
  logic cfg_legacy = 1'b0;
  logic conv_start = 1'b0;
  logic [4:0] cfg_hi_q;
  logic [2:0] cfg_lo_q;
  logic cfg_legacy_q, qclk, rise_stb, fall_stb, conv_busy, conv_done;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  conv_clk_div uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo),
    .cfg_legacy(cfg_legacy), .cfg_hi_q(cfg_hi_q), .cfg_lo_q(cfg_lo_q),
    .cfg_legacy_q(cfg_legacy_q), .qclk(qclk), .rise_stb(rise_stb),
    .fall_stb(fall_stb), .conv_start(conv_start), .conv_busy(conv_busy),
    .conv_done(conv_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input int h, input int l, input bit g);
    cfg_we = 1'b1; cfg_hi = 5'(h); cfg_lo = 3'(l); cfg_legacy = g;
    tick();
    cfg_we = 1'b0;
  endtask

  // Syncs to a rise strobe, measures one high and one low phase, ends on the next rise
  task automatic measure(output int hl, output int ll, output bit strobes_ok);
    strobes_ok = 1'b1;
    hl = 0; ll = 0;
    while (!rise_stb) tick();
    while (qclk) begin
      if (rise_stb != (hl == 0) || fall_stb) strobes_ok = 1'b0;
      hl++;
      tick();
    end
    while (!qclk) begin
      if (fall_stb != (ll == 0) || rise_stb) strobes_ok = 1'b0;
      ll++;
      tick();
    end
  endtask

  task automatic conversion(input bit extra_start);
    int n = 0;
    int guard = 0;
    bit prev_rise = 1'b0;
    conv_start = 1'b1;
    tick();
    conv_start = 1'b0;
    chk(conv_busy == 1'b1, "R8 busy after start", conv_busy, 1);
    while (!conv_done && guard < 2000) begin
      if (extra_start && n == 5) conv_start = 1'b1;
      else conv_start = 1'b0;
      if (rise_stb) n++;
      prev_rise = rise_stb;
      guard++;
      tick();
    end
    conv_start = 1'b0;
    chk(n == 14, extra_start ? "R9 edges with restart" : "R8 edges counted", n, 14);
    chk(prev_rise && !conv_busy, "R8 done follows 14th rise", {prev_rise, conv_busy}, 2);
    tick();
    chk(conv_done == 1'b0, "R8 done one cycle", conv_done, 0);
  endtask

  initial begin
    int hl, ll, hl2, ll2;
    bit sok;
    repeat (4) tick();
    rst = 1'b0;
    chk(qclk == 0 && rise_stb == 0 && fall_stb == 0, "R1 outputs low", qclk, 0);
    chk(cfg_hi_q == 0 && cfg_lo_q == 0 && cfg_legacy_q == 0, "R1 fields zero", cfg_hi_q, 0);
    chk(conv_busy == 0 && conv_done == 0, "R1 timer idle", conv_busy, 0);
    tick();
    chk(qclk == 1 && rise_stb == 1, "R1 first rise", qclk, 1);
    measure(hl, ll, sok);
    chk(hl == 1 && ll == 1, "R10 minimum period", hl + ll, 2);

    for (int h = 0; h < 32; h++) begin
      for (int l = 0; l < 8; l++) begin
        wr(h, l, 1'b0);
        if (h == 0 && l == 0)
          chk(cfg_hi_q == 5'(h) && cfg_lo_q == 3'(l), "R5 readback", cfg_hi_q, h);
        measure(hl, ll, sok);
        measure(hl, ll, sok);
        chk(hl == h + 1, "R2 high length", hl, h + 1);
        chk(ll == l + 1, "R3 low length", ll, l + 1);
        chk(sok, "R4 strobe placement", sok, 1);
        if (h == 11 && l == 7) chk(hl + ll == 20, "R3 period 11/7", hl + ll, 20);
        if (h == 7 && l == 7) chk(hl + ll == 16, "R3 period 7/7", hl + ll, 16);
      end
    end

    wr(19, 6, 1'b0);
    chk(cfg_hi_q == 19 && cfg_lo_q == 6, "R5 readback", cfg_hi_q, 19);

    wr(20, 7, 1'b0);
    measure(hl, ll, sok);
    while (!rise_stb) tick();
    hl = 0;
    while (qclk) begin
      hl++;
      if (hl == 4) begin cfg_we = 1'b1; cfg_hi = 5'd0; cfg_lo = 3'd0; end
      else cfg_we = 1'b0;
      tick();
    end
    cfg_we = 1'b0;
    chk(hl == 21, "R6 current high kept", hl, 21);
    ll = 0;
    while (!qclk) begin ll++; tick(); end
    chk(ll == 1, "R6 next low uses new value", ll, 1);
    measure(hl, ll, sok);
    chk(hl == 1 && ll == 1, "R6 new values applied", hl + ll, 2);

    wr(5, 3, 1'b0);
    measure(hl, ll, sok);
    measure(hl, ll, sok);
    wr(5, 3, 1'b1);
    chk(cfg_legacy_q == 1, "R7 legacy readback", cfg_legacy_q, 1);
    measure(hl2, ll2, sok);
    measure(hl2, ll2, sok);
    chk(hl2 == hl && ll2 == ll && hl2 == 6 && ll2 == 4, "R7 legacy no effect", hl2 + ll2, 10);
    chk(sok, "R7 strobes unchanged", sok, 1);

    wr(3, 2, 1'b0);
    measure(hl, ll, sok);
    conversion(1'b0);
    conversion(1'b1);
    wr(0, 0, 1'b0);
    measure(hl, ll, sok);
    conversion(1'b0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule